// File: doc/BRIEF.md
# Event-Counted Implication Monitor

This block watches a design at run time and checks properties whose timing is counted in occurrences of an event signal rather than in clock cycles. A trigger pulse opens a check. From then on, every cycle in which the event input is high advances that check's occurrence count. Cycles in which the event is low are skipped. On the occurrences the mode selects, the condition input is examined. When the property is broken, a one-cycle failure pulse is raised.

There are three modes, fixed by a parameter:
- **Single occurrence.** The condition must be true on the K-th occurrence.
- **Every occurrence.** The condition must be true on each occurrence from I through J.
- **Any occurrence.** The condition must be true on at least one occurrence from I through J.

Triggers may overlap. Each one claims its own tracking slot, and the number of slots is a parameter. A trigger that finds every slot taken raises a sticky error.

By default, an event seen in the trigger's own cycle is that trigger's first occurrence. A parameter can exclude the trigger cycle instead, so that counting starts one cycle later.

Top module: `ecic_monitor`

## Requirements
- R1: After reset, `fail` and `error` are low and no trigger is being tracked.
- R2: With trigger-cycle counting enabled (SKIP_TRIG=0), an `evt` high in the same cycle as `trig` is occurrence number 1 for that trigger.
- R3: With SKIP_TRIG=1, an `evt` in the trigger cycle is not counted, and `cond` in that cycle has no effect. The first `evt` in a later cycle is occurrence 1.
- R4: Cycles with `evt` low neither advance any occurrence count nor cause a check, whatever the value of `cond`.
- R5: In single mode (MODE=CHK_ONE, K=ORD_LO), `cond` is examined only on occurrence K. `cond` low on any other occurrence causes no failure.
- R6: In every-occurrence mode (MODE=CHK_EVERY), `cond` low on any occurrence numbered ORD_LO through ORD_HI causes a failure.
- R7: In any-occurrence mode (MODE=CHK_ANY), a failure is raised at occurrence ORD_HI if and only if `cond` was low on all occurrences ORD_LO through ORD_HI.
- R8: Up to SLOTS overlapping triggers are tracked independently, each with its own occurrence count.
- R9: A `trig` arriving while all SLOTS slots are in use sets `error`, which stays high until reset.
- R10: `fail` is registered. It is high for exactly one cycle, the cycle after the `evt` cycle that decides a violation.
- R11: A slot is released at its last checked occurrence (K, or ORD_HI). It can accept a new trigger from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Starts a new counted check |
| evt | input | 1 | Qualifying event; each high cycle is one occurrence |
| cond | input | 1 | Condition examined on the selected occurrences |
| fail | output | 1 | One-cycle pulse when a check is violated |
| error | output | 1 | Sticky flag: a trigger found no free slot |

## Verification
The bench builds three copies side by side, all with two slots:
- a single-occurrence copy with K=3;
- an every-occurrence copy with window 2..3;
- an any-occurrence copy with window 1..2 that excludes the trigger cycle.

All three copies see the same stimulus, so one trace shows how each mode judges the same occurrence stream. The short windows let slots retire within a few events. Because there are only two slots, a third trigger reaches overflow, and a retire followed by a reclaim shows that a released slot can be used again.

// File: rtl/ecic_pkg.sv
package ecic_pkg;

    typedef enum logic [1:0] {
        CHK_ONE   = 2'd0,
        CHK_EVERY = 2'd1,
        CHK_ANY   = 2'd2
    } chk_mode_e;

    typedef struct packed {
        logic fail;
        logic err;
    } mon_out_t;

endpackage

// File: rtl/ecic_alloc.sv
module ecic_alloc #(
    parameter int N = 4
) (
    input  logic         trig,
    input  logic [N-1:0] busy,
    output logic [N-1:0] grant,
    output logic         ovf
);

    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i] && !found) begin
                grant[i] = trig;
                found    = 1'b1;
            end
        end
        ovf = trig && !found;
    end

endmodule

// File: rtl/ecic_slot.sv
module ecic_slot
    import ecic_pkg::*;
#(
    parameter chk_mode_e MODE      = CHK_ONE,
    parameter int        WIN_LO    = 4,
    parameter int        WIN_HI    = 4,
    parameter bit        SKIP_TRIG = 1'b0,
    parameter int        CW        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic claim,
    input  logic evt,
    input  logic cond,
    output logic busy,
    output logic viol
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          hit;
    } slot_t;

    slot_t         st_d, st_q, base;
    logic          counting;
    logic [CW-1:0] n;
    logic          inwin;
    logic          hit_n;

    always_comb begin
        base = st_q;
        if (!st_q.busy && claim) begin
            base = '{busy: 1'b1, cnt: '0, hit: 1'b0};
        end
        counting = evt && (st_q.busy || (claim && !SKIP_TRIG));
        st_d     = base;
        viol     = 1'b0;
        n        = '0;
        inwin    = 1'b0;
        hit_n    = 1'b0;
        if (counting) begin
            n     = base.cnt + 1'b1;
            inwin = (n >= CW'(WIN_LO)) && (n <= CW'(WIN_HI));
            hit_n = base.hit | (inwin & cond);
            if (MODE == CHK_ANY) begin
                viol = (n == CW'(WIN_HI)) && !hit_n;
            end else begin
                viol = inwin && !cond;
            end
            st_d.cnt = n;
            st_d.hit = hit_n;
            if (n == CW'(WIN_HI)) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    // R11: an occupied slot never holds a count at or past its last occurrence
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < CW'(WIN_HI)));

endmodule

// File: rtl/ecic_monitor.sv
module ecic_monitor
    import ecic_pkg::*;
#(
    parameter chk_mode_e MODE      = CHK_ONE,
    parameter int        ORD_LO    = 4,
    parameter int        ORD_HI    = 4,
    parameter int        SLOTS     = 4,
    parameter bit        SKIP_TRIG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic evt,
    input  logic cond,
    output logic fail,
    output logic error
);

    localparam int WIN_LO = ORD_LO;
    localparam int WIN_HI = (MODE == CHK_ONE) ? ORD_LO : ORD_HI;
    localparam int CW     = $clog2(WIN_HI + 1);

    logic [SLOTS-1:0] busy;
    logic [SLOTS-1:0] grant;
    logic [SLOTS-1:0] viol;
    logic             ovf;
    mon_out_t         out_d, out_q;

    ecic_alloc #(.N(SLOTS)) u_alloc (
        .trig  (trig),
        .busy  (busy),
        .grant (grant),
        .ovf   (ovf)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ecic_slot #(
            .MODE      (MODE),
            .WIN_LO    (WIN_LO),
            .WIN_HI    (WIN_HI),
            .SKIP_TRIG (SKIP_TRIG),
            .CW        (CW)
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .claim (grant[s]),
            .evt   (evt),
            .cond  (cond),
            .busy  (busy[s]),
            .viol  (viol[s])
        );
    end

    always_comb begin
        out_d      = out_q;
        out_d.fail = |viol;
        out_d.err  = out_q.err | ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fail  = out_q.fail;
    assign error = out_q.err;

    // R8: a trigger is only handed to a free slot, and to at most one
    assert_grant_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & busy) == '0) && $onehot0(grant));

    // R9: overflow when all slots are taken
    assert_ovf_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (&busy)) |=> error);

    // R9: error is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    // R10: a failure is always decided by an event one cycle earlier
    assert_fail_after_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(evt));

endmodule

// File: tb/ecic_monitor_tb.sv
`timescale 1ns/1ps
module ecic_monitor_tb;
    import ecic_pkg::*;

    localparam real HALF = 2.0;
    localparam int  NVEC = 12;
    // {trig, evt, cond, fail_one, fail_every, fail_any}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b111_000,  // trigger + event same cycle (R2)
        6'b000_000,  // gap (R4)
        6'b010_010,  // occ2: every-mode violation (R6); single ignores (R5)
        6'b000_000,  // gap (R4)
        6'b011_000,  // occ3: all pass, slots retire (R11)
        6'b110_000,  // new trigger with event
        6'b111_000,  // overlapping trigger (R8)
        6'b010_110,  // single K=3 fails (R2,R5); any already hit (R7)
        6'b011_000,  // second slot completes cleanly (R8)
        6'b110_000,  // trigger, any-mode skips this cycle (R3)
        6'b010_010,  // every fails at occ2
        6'b010_111   // all three fail; any never hit (R7)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0, evt = 1'b0, cond = 1'b0;
    logic fa, fb, fc, ea, eb, ec;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #(HALF) clk = ~clk;

    ecic_monitor #(.MODE(CHK_ONE), .ORD_LO(3), .ORD_HI(3), .SLOTS(2), .SKIP_TRIG(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .evt(evt), .cond(cond), .fail(fa), .error(ea));
    ecic_monitor #(.MODE(CHK_EVERY), .ORD_LO(2), .ORD_HI(3), .SLOTS(2), .SKIP_TRIG(1'b0)) u_dut_every (
        .clk(clk), .rst_n(rst_n), .trig(trig), .evt(evt), .cond(cond), .fail(fb), .error(eb));
    ecic_monitor #(.MODE(CHK_ANY), .ORD_LO(1), .ORD_HI(2), .SLOTS(2), .SKIP_TRIG(1'b1)) u_dut_any (
        .clk(clk), .rst_n(rst_n), .trig(trig), .evt(evt), .cond(cond), .fail(fc), .error(ec));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic e, input logic c);
        trig = t; evt = e; cond = c;
        @(posedge clk);
        @(negedge clk);
        trig = 1'b0; evt = 1'b0; cond = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trig = 1'b0; evt = 1'b0; cond = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "fail one after reset", fa, 1'b0);
        chk("R1", "fail every after reset", fb, 1'b0);
        chk("R1", "fail any after reset", fc, 1'b0);
        chk("R1", "error one after reset", ea, 1'b0);
        chk("R1", "error any after reset", ec, 1'b0);
    endtask

    initial begin
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk("R5", $sformatf("row %0d single fail", i), fa, VEC[i][2]);
            chk("R6", $sformatf("row %0d every fail", i), fb, VEC[i][1]);
            chk("R7", $sformatf("row %0d any fail", i), fc, VEC[i][0]);
            chk("R9", $sformatf("row %0d no overflow", i), ea, 1'b0);
        end

        // R3: trigger-cycle event and condition ignored in the skipping copy
        // R2: the same cycle is occurrence 1 in the single copy
        do_reset();
        step(1'b1, 1'b1, 1'b1);
        chk("R3", "any no fail on trigger cycle", fc, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R3", "any no fail at first counted occ", fc, 1'b0);
        chk("R2", "single no fail at occ2", fa, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R3", "any fails, trigger-cycle cond did not count", fc, 1'b1);
        chk("R2", "single fails at occ3 counting trigger cycle", fa, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk("R10", "single fail lasts one cycle", fa, 1'b0);

        // R9: overflow with two slots, sticky until reset
        do_reset();
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R9", "no error with slots filled", ea, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R9", "error on third trigger single", ea, 1'b1);
        chk("R9", "error on third trigger any", ec, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        chk("R9", "error sticky", ea, 1'b1);

        // R11: retired slot becomes reusable
        do_reset();
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        chk("R11", "single reclaim after retire", ea, 1'b0);
        chk("R11", "every reclaim after retire", eb, 1'b0);
        chk("R11", "any reclaim after retire", ec, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R11", "single full again overflows", ea, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(HALF * 2.0 * 200000.0);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule